// File: doc/BRIEF.md
# Error-Tolerant Approximate Adder

This block adds two unsigned N-bit operands with a deliberately approximate rule, giving up some accuracy for a short critical path and little switching activity. The operand bits are split in two. The high-order section is added exactly with a chain of full adders. The low-order section is added without any carry at all.

In the low section, each bit position gets its own sum cell. A saturation chain looks for the most significant low bit where both operands are 1. From that position down to bit 0, every sum bit is forced to 1. Above that position, each sum bit is the plain XOR of the two operand bits. No carry passes from the low section into the high section, so the high chain always starts with a carry-in of 0.

A parameter chooses between a purely combinational result and a result held in an output register. The registered form gives a clean timing path for tests.

Top module: `eta_adder_top`

## Requirements
- R1: Result bits [WIDTH-1:LO_WIDTH] equal (A[WIDTH-1:LO_WIDTH] + B[WIDTH-1:LO_WIDTH]) modulo 2^(WIDTH-LO_WIDTH), computed with a carry-in of 0.
- R2: The carry-out equals bit WIDTH-LO_WIDTH of the unreduced sum of the two high operand sections.
- R3: When no low-section position k has A[k]=B[k]=1, result bits [LO_WIDTH-1:0] equal A[LO_WIDTH-1:0] XOR B[LO_WIDTH-1:0].
- R4: When k is the highest low-section position with A[k]=B[k]=1, result bits k down to 0 are all 1, and each low result bit above k is the XOR of its operand bits.
- R5: Changing only the low-section operand bits leaves the high result bits and the carry-out unchanged.
- R6: When no low-section position has both operand bits at 1, {carry-out, result} equals the exact sum A+B.
- R7: WIDTH and LO_WIDTH are parameters with defaults of 16 and 4, and the valid range is 1 <= LO_WIDTH < WIDTH. Other legal values give the same rules.
- R8: With REG_OUT=1 (the default), the result and carry-out for the operands present at a rising clock edge appear just after that edge, and an active-low reset clears both outputs to 0 at once. With REG_OUT=0, the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register (REG_OUT=1) |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH | Approximate sum |
| cout_o | output | 1 | Carry-out of the high section |

## Verification
The bench builds two instances. The first uses the defaults (16 bits, 4 low bits, registered). It is fed through a scoreboard with directed patterns: saturation at each low position, and operands that differ only in their low bits. It also receives carries that ripple through the whole high section. The second instance is 8 bits wide with 3 low bits and is combinational. Its width is small enough to sweep all 65536 operand pairs, which covers every generate position, every high-section carry and the non-default parameter path. All results are compared with a bit-exact model of the approximation rule. The largest distance from the exact sum is also reported.

// File: rtl/eta_pkg.sv
package eta_pkg;
  localparam int unsigned ETA_WIDTH_DEF    = 16;
  localparam int unsigned ETA_LO_WIDTH_DEF = 4;
endpackage

// File: rtl/eta_full_adder.sv
module eta_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic prop;
  assign prop = a_i ^ b_i;
  assign s_o  = prop ^ c_i;
  assign c_o  = (a_i & b_i) | (c_i & prop);
endmodule

// File: rtl/eta_ripple_section.sv
module eta_ripple_section #(
  parameter int unsigned WIDTH = 12
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] carry;
  assign carry[0] = cin_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    eta_full_adder i_fa (
      .a_i (a_i[g]),
      .b_i (b_i[g]),
      .c_i (carry[g]),
      .s_o (sum_o[g]),
      .c_o (carry[g+1])
    );
  end

  assign cout_o = carry[WIDTH];
endmodule

// File: rtl/eta_carry_free_section.sv
module eta_carry_free_section #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] ctl;

  assign gen = a_i & b_i;

  // saturation chain: once a generate bit is seen from the top, all lower bits are forced
  always_comb begin
    logic run;
    run = 1'b0;
    for (int k = WIDTH - 1; k >= 0; k--) begin
      run    = run | gen[k];
      ctl[k] = run;
    end
  end

  // per-bit modified XOR cell
  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    assign sum_o[g] = ctl[g] | (a_i[g] ^ b_i[g]);
  end
endmodule

// File: rtl/eta_adder_top.sv
module eta_adder_top
  import eta_pkg::*;
#(
  parameter int unsigned WIDTH    = ETA_WIDTH_DEF,
  parameter int unsigned LO_WIDTH = ETA_LO_WIDTH_DEF,
  parameter bit          REG_OUT  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned HI_WIDTH = WIDTH - LO_WIDTH;

  logic [HI_WIDTH-1:0] a_hi, b_hi, hi_sum;
  logic [LO_WIDTH-1:0] a_lo, b_lo, lo_sum;
  logic                hi_cout;
  logic [WIDTH-1:0]    sum_d;

  assign a_hi = a_i[WIDTH-1:LO_WIDTH];
  assign b_hi = b_i[WIDTH-1:LO_WIDTH];
  assign a_lo = a_i[LO_WIDTH-1:0];
  assign b_lo = b_i[LO_WIDTH-1:0];

  eta_ripple_section #(.WIDTH(HI_WIDTH)) i_hi (
    .a_i    (a_hi),
    .b_i    (b_hi),
    .cin_i  (1'b0),
    .sum_o  (hi_sum),
    .cout_o (hi_cout)
  );

  eta_carry_free_section #(.WIDTH(LO_WIDTH)) i_lo (
    .a_i   (a_lo),
    .b_i   (b_lo),
    .sum_o (lo_sum)
  );

  assign sum_d = {hi_sum, lo_sum};

  if (REG_OUT) begin : g_reg
    logic [WIDTH-1:0] sum_q;
    logic             cout_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_q  <= '0;
        cout_q <= 1'b0;
      end else begin
        sum_q  <= sum_d;
        cout_q <= hi_cout;
      end
    end
    assign sum_o  = sum_q;
    assign cout_o = cout_q;

    p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> ({cout_o, sum_o} == $past({hi_cout, sum_d})));
  end else begin : g_comb
    assign sum_o  = sum_d;
    assign cout_o = hi_cout;
  end

  // the exact high chain, compared with arithmetic
  p_hi_exact_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_sum == HI_WIDTH'(a_hi + b_hi));
  p_cout_exact_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cout == (({1'b0, a_hi} + {1'b0, b_hi}) >> HI_WIDTH));
  // low section without any generate behaves as XOR
  p_no_gen_xor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_lo & b_lo) == '0) |-> (lo_sum == (a_lo ^ b_lo)));
  // any generate forces bit 0 and covers every generate position
  p_lsb_saturate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(a_lo & b_lo)) |-> lo_sum[0]);
  p_gen_covered_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_lo & b_lo & ~lo_sum) == '0));
endmodule

// File: tb/test_eta_adder_top.sv
module test_eta_adder_top;
  localparam int W1 = 16, L1 = 4;
  localparam int W2 = 8,  L2 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W1-1:0] a16 = '0, b16 = '0, s16;
  logic          c16;
  logic [W2-1:0] a8 = '0, b8 = '0, s8;
  logic          c8;

  eta_adder_top i_eta_adder_top (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a16), .b_i(b16), .sum_o(s16), .cout_o(c16)
  );

  eta_adder_top #(.WIDTH(W2), .LO_WIDTH(L2), .REG_OUT(1'b0)) i_eta_adder_top_w8 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a8), .b_i(b8), .sum_o(s8), .cout_o(c8)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int max_err = 0;

  typedef struct {
    logic [W1:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  // bit-exact model of the approximation rule
  function automatic logic [32:0] model(int w, int l, logic [31:0] a, logic [31:0] b);
    logic [31:0] hs, s;
    bit hit;
    hs  = (a >> l) + (b >> l);
    s   = (hs << l) & ((32'd1 << w) - 1);
    hit = 1'b0;
    for (int k = l - 1; k >= 0; k--) begin
      if (a[k] & b[k]) hit = 1'b1;
      s[k] = hit | (a[k] ^ b[k]);
    end
    return {hs[w-l], s};
  endfunction

  task automatic check(string req, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive16(logic [W1-1:0] a, logic [W1-1:0] b, string req);
    logic [32:0] m;
    item_t it;
    @(negedge clk);
    a16 = a;
    b16 = b;
    m = model(W1, L1, 32'(a), 32'(b));
    it.exp = {m[32], m[W1-1:0]};
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: registered result is visible just after the edge following the drive
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.req, 33'({c16, s16}), 33'(it.exp));
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // reset state, R8
    a16 = 16'hFFFF;
    b16 = 16'h0001;
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset clear", 33'({c16, s16}), 33'd0);
    @(negedge clk);
    rst_n = 1'b1;
    a16 = '0;
    b16 = '0;
    @(posedge clk);
    // latency R8: a drive at a negedge must not show before the next edge
    @(negedge clk);
    a16 = 16'h1234;
    b16 = 16'h0101;
    #1;
    check("R8 held until edge", 33'({c16, s16}), 33'd0);
    @(posedge clk);
    #1;
    check("R8 one-cycle result", 33'({c16, s16}), 33'h01335);

    drive16(16'h0005, 16'h000A, "R3 xor no generate");
    drive16(16'h0005, 16'h0004, "R4 saturate at bit2");
    drive16(16'h0009, 16'h0008, "R4 saturate at bit3");
    drive16(16'h0001, 16'h0001, "R4 saturate at bit0");
    drive16(16'h000A, 16'h0002, "R4 bits above k xor");
    drive16(16'hFFF0, 16'h0010, "R1 R2 full ripple carry");
    drive16(16'h8000, 16'h8000, "R2 carry-out only");
    drive16(16'h1230, 16'h4560, "R5 low zero");
    drive16(16'h123F, 16'h456F, "R5 low all ones same upper");
    drive16(16'h7FF2, 16'h0004, "R6 exact when no generate");
    drive16(16'hABC8, 16'h5438, "R6 R4 mixed");
    for (int i = 0; i < 200; i++)
      drive16(16'(i * 16'h3B1D + 7), 16'(i * 16'h91E7 + 3), "R1 R4 sweep");
    repeat (3) @(posedge clk);

    // R5 at the ports: upper result unchanged across all low operand values
    begin
      logic [W1:0] ref_hi;
      for (int lo = 0; lo < 256; lo++) begin
        @(negedge clk);
        a16 = {12'hC3A, 4'(lo)};
        b16 = {12'h5E7, 4'(lo >> 4)};
        @(posedge clk);
        #1;
        if (lo == 0) ref_hi = {c16, s16[W1-1:L1], 4'h0};
        check("R5 upper independent of low", 33'({c16, s16[W1-1:L1]}),
              33'(ref_hi[W1:L1]));
      end
    end

    // R7 non-default widths, combinational: exhaustive sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        logic [32:0] m;
        int err;
        a8 = 8'(a);
        b8 = 8'(b);
        #1;
        m = model(W2, L2, 32'(a), 32'(b));
        check("R7 8/3 comb rule", 33'({c8, s8}), 33'({m[32], m[W2-1:0]}));
        if ((a[L2-1:0] & b[L2-1:0]) == 0)
          check("R6 8/3 exact", 33'({c8, s8}), 33'(a + b));
        err = (a + b) - int'({c8, s8});
        if (err < 0) err = -err;
        if (err > max_err) max_err = err;
      end
    end
    $display("info: largest distance from exact sum (8/3) = %0d", max_err);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule